// File: doc/BRIEF.md
# GPIO Pad Controller with Shared Interrupt Lines

This block is a register-mapped controller for a bank of general-purpose pads arranged in groups. Software reaches it through single-beat 32-bit reads and writes. Each pad owns two configuration words. The first holds the synchronised input level, the level the pad drives out, and a 4-bit selector that names one of sixteen shared interrupt lines. The second holds the trigger kind and an input-inversion code.

Pad inputs are resynchronised and may be inverted. A per-pad detector then turns them into events. The events of all pads that point at the same line are merged into that line. A line that fires sets a sticky bit in a status register, and software clears that bit by writing a one to it. An enable register gates the status bits, and the OR of the gated bits drives one registered interrupt output.

The number of groups and the number of pads in each group are parameters. Slots above a group's pad count have no storage.

Top module: `gpio_pad_irq_ctrl`

## Requirements
- R1: Status sits at byte offset 0x300 and enable at 0x380. Each holds one bit per line for 16 lines, and bits 31:16 read as 0. The enable register reads back the low 16 bits last written.
- R2: A write to the status register clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Without such a write, a set status bit stays set.
- R3: `irq_o` is a register that, one cycle after any change, equals the OR over lines of (status AND enable). With enable 0, `irq_o` is 0.
- R4: Pad p has its first word at 0x4400 + 1024*(p/15) + 8*(p%15) and its second word 4 bytes higher. In the first word, bit 1 drives `pad_out_o[p]` and bits 31:28 select the interrupt line. Both read back.
- R5: Bit 0 of the first word reads `pad_in_i[p]` after a two-flop synchroniser, without inversion, and writes to bit 0 have no effect.
- R6: Bits 2:0 of the second word set the trigger: 0 none, 1 falling edge, 2 rising edge, 3 both edges, 4 level. Codes 5 to 7 produce no events.
- R7: Bits 7:4 of the second word read back as written. The code 0x4 (bit 6 alone) inverts the synchronised input before detection, so a low input counts as active for the level trigger.
- R8: While a level-triggered pad is active, its line's status bit is set again every cycle, and an event wins over a clear in the same cycle. A clear therefore only sticks once the input is inactive.
- R9: Events from several pads that select the same line are ORed into that line.
- R10: Every request gets a response on the next cycle. An access that is unaligned (address bits 1:0 not 0) or at or above the mapped size 0x4400 + 1024*groups returns `rsp_err_o` = 1 with data 0, and a write with such an address changes nothing.
- R11: A pad slot at or above its group's pad count, and any other unmapped in-range address, reads as 0 without error. Writes to it are ignored, and the pad output of a missing pad stays 0.
- R12: Reset clears status, enable, `irq_o`, every trigger, inversion, line and output field, and the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access rejected |
| pad_in_i | input | 15*NUM_GROUPS | Asynchronous pad inputs, index group*15+slot |
| pad_out_o | output | 15*NUM_GROUPS | Pad output levels |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a level-triggered, inverted pad whose input is still active when software clears its status bit. An event and a clear then collide in the same cycle, and the clear must lose. The bench sets up this case by programming inversion together with the level trigger while the pad input is held low. It then issues the clear while the input stays low and reads the status back. Next it releases the input and clears again, which shows that the clear now sticks. Edge modes are driven through rise, fall and both-edge sequences, and in each case the bench waits past the synchroniser and detector latency before it reads status.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned NUM_LINES    = 16;
  localparam int unsigned PADS_PER_GRP = 15;
  localparam int unsigned GRP_STRIDE   = 1024;
  localparam logic [31:0] STAT_OFF     = 32'h0000_0300;
  localparam logic [31:0] EN_OFF       = 32'h0000_0380;
  localparam logic [31:0] PAD_BASE     = 32'h0000_4400;
  localparam logic [3:0]  INV_RX_CODE  = 4'h4;

  typedef enum logic [2:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

  function automatic logic pad_event(input logic [2:0] trig, input logic cur, input logic prev);
    logic ev;
    case (trig)
      TRIG_FALL:  ev = prev & ~cur;
      TRIG_RISE:  ev = ~prev & cur;
      TRIG_BOTH:  ev = prev ^ cur;
      TRIG_LEVEL: ev = cur;
      default:    ev = 1'b0;
    endcase
    return ev;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pad_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_cfg0_i,
  input  logic        wr_cfg1_i,
  input  logic        wr_tx_i,
  input  logic [3:0]  wr_line_i,
  input  logic [2:0]  wr_trig_i,
  input  logic [3:0]  wr_inv_i,
  input  logic        rx_i,
  output logic [31:0] cfg0_o,
  output logic [31:0] cfg1_o,
  output logic        tx_o,
  output logic [3:0]  line_o,
  output logic        evt_o
);
  logic       tx_q;
  logic [3:0] line_q;
  logic [2:0] trig_q;
  logic [3:0] inv_q;
  logic       det_q;
  logic       det;

  assign det = rx_i ^ (inv_q == INV_RX_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      line_q <= '0;
      trig_q <= TRIG_OFF;
      inv_q  <= '0;
      det_q  <= 1'b0;
    end else begin
      det_q <= det;
      if (wr_cfg0_i) begin
        tx_q   <= wr_tx_i;
        line_q <= wr_line_i;
      end
      if (wr_cfg1_i) begin
        trig_q <= wr_trig_i;
        inv_q  <= wr_inv_i;
      end
    end
  end

  assign evt_o  = pad_event(trig_q, det, det_q);
  assign tx_o   = tx_q;
  assign line_o = line_q;
  assign cfg0_o = {line_q, 26'b0, tx_q, rx_i};
  assign cfg1_o = {24'b0, inv_q, 1'b0, trig_q};
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_evt_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] status_o,
  output logic [LINES-1:0] enable_o,
  output logic             irq_o
);
  logic [LINES-1:0] status_q, enable_q, clr_mask;
  logic             irq_q;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      // a fresh event wins over a clear in the same cycle
      status_q <= (status_q & ~clr_mask) | line_evt_i;
      if (en_we_i) enable_q <= wdata_i;
      irq_q <= |(status_q & enable_q);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_pad_irq_ctrl.sv
module gpio_pad_irq_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned             NUM_GROUPS = 2,
  parameter logic [NUM_GROUPS*4-1:0] GRP_PADS   = {4'd6, 4'd8},
  parameter int unsigned             ADDR_W     = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_valid_i,
  input  logic                               req_write_i,
  input  logic [ADDR_W-1:0]                  req_addr_i,
  input  logic [31:0]                        req_wdata_i,
  output logic                               rsp_valid_o,
  output logic [31:0]                        rsp_rdata_o,
  output logic                               rsp_err_o,
  input  logic [NUM_GROUPS*PADS_PER_GRP-1:0] pad_in_i,
  output logic [NUM_GROUPS*PADS_PER_GRP-1:0] pad_out_o,
  output logic                               irq_o
);
  localparam int unsigned NUM_PADS  = NUM_GROUPS * PADS_PER_GRP;
  localparam logic [31:0] MAP_BYTES = PAD_BASE + 32'(NUM_GROUPS * GRP_STRIDE);

  logic [31:0] addr32, off;
  logic        acc_ok, in_pad, word_sel, wr_ok;
  logic [21:0] grp_sel;
  logic [6:0]  slot_sel;
  logic        stat_clr_we, en_we;

  assign addr32   = 32'(req_addr_i);
  assign acc_ok   = (addr32[1:0] == 2'b00) && (addr32 < MAP_BYTES);
  assign in_pad   = addr32 >= PAD_BASE;
  assign off      = addr32 - PAD_BASE;
  assign grp_sel  = off[31:10];
  assign slot_sel = off[9:3];
  assign word_sel = off[2];
  assign wr_ok    = req_valid_i && req_write_i && acc_ok;

  assign stat_clr_we = wr_ok && (addr32 == STAT_OFF);
  assign en_we       = wr_ok && (addr32 == EN_OFF);

  logic [NUM_PADS-1:0] rx_sync, pad_hit, pad_evt, unused_rx;
  logic [31:0]         pad_cfg0 [NUM_PADS];
  logic [31:0]         pad_cfg1 [NUM_PADS];
  logic [3:0]          pad_line [NUM_PADS];

  gpio_sync2 #(.WIDTH(NUM_PADS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (rx_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar s = 0; s < PADS_PER_GRP; s++) begin : g_slot
      localparam int unsigned P = g * PADS_PER_GRP + s;
      if (s < int'(GRP_PADS[g*4 +: 4])) begin : g_pad
        assign pad_hit[P]   = in_pad && (grp_sel == 22'(g)) && (slot_sel == 7'(s));
        assign unused_rx[P] = 1'b0;
        gpio_pad_cell u_cell (
          .clk_i    (clk_i),
          .rst_ni   (rst_ni),
          .wr_cfg0_i(wr_ok && pad_hit[P] && !word_sel),
          .wr_cfg1_i(wr_ok && pad_hit[P] && word_sel),
          .wr_tx_i  (req_wdata_i[1]),
          .wr_line_i(req_wdata_i[31:28]),
          .wr_trig_i(req_wdata_i[2:0]),
          .wr_inv_i (req_wdata_i[7:4]),
          .rx_i     (rx_sync[P]),
          .cfg0_o   (pad_cfg0[P]),
          .cfg1_o   (pad_cfg1[P]),
          .tx_o     (pad_out_o[P]),
          .line_o   (pad_line[P]),
          .evt_o    (pad_evt[P])
        );
      end else begin : g_absent
        assign pad_hit[P]   = 1'b0;
        assign unused_rx[P] = rx_sync[P];
        assign pad_cfg0[P]  = '0;
        assign pad_cfg1[P]  = '0;
        assign pad_out_o[P] = 1'b0;
        assign pad_line[P]  = '0;
        assign pad_evt[P]   = 1'b0;
      end
    end
  end

  // merge pad events onto their selected lines
  logic [NUM_LINES-1:0] line_evt;
  always_comb begin
    line_evt = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (pad_evt[p]) line_evt[pad_line[p]] = 1'b1;
    end
  end

  logic [NUM_LINES-1:0] status_w, enable_w;

  gpio_irq_core #(.LINES(NUM_LINES)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_evt_i(line_evt),
    .clr_we_i  (stat_clr_we),
    .en_we_i   (en_we),
    .wdata_i   (req_wdata_i[NUM_LINES-1:0]),
    .status_o  (status_w),
    .enable_o  (enable_w),
    .irq_o     (irq_o)
  );

  logic [31:0] rd_data;
  always_comb begin
    rd_data = '0;
    if (addr32 == STAT_OFF) rd_data = 32'(status_w);
    if (addr32 == EN_OFF)   rd_data = 32'(enable_w);
    for (int p = 0; p < NUM_PADS; p++) begin
      if (pad_hit[p]) rd_data = word_sel ? pad_cfg1[p] : pad_cfg0[p];
    end
    if (!acc_ok) rd_data = '0;
  end

  logic        rsp_valid_q, rsp_err_q;
  logic [31:0] rsp_rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i && !acc_ok;
      rsp_rdata_q <= (req_valid_i && !req_write_i) ? rd_data : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;

  logic unused_bits;
  assign unused_bits = ^{req_wdata_i[27:16], req_wdata_i[3], off[1:0], unused_rx};
endmodule

// File: rtl/gpio_pad_irq_chk.sv
module gpio_pad_irq_chk #(
  parameter int unsigned LINES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             rsp_valid_i,
  input logic             rsp_err_i,
  input logic [31:0]      rsp_rdata_i,
  input logic [LINES-1:0] status_i,
  input logic [LINES-1:0] enable_i,
  input logic [LINES-1:0] line_evt_i,
  input logic             clr_we_i,
  input logic [31:0]      wdata_i,
  input logic             irq_i
);
  AST_IRQ_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & enable_i)) |=> irq_i); // R3

  AST_IRQ_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_i & enable_i)) |=> !irq_i); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_i & $past(wdata_i[LINES-1:0] & ~line_evt_i)) == '0)); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (($past(status_i) & ~status_i) == '0)); // R2

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_evt_i != '0) |=> ((status_i & $past(line_evt_i)) == $past(line_evt_i))); // R8

  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_i |-> (rsp_rdata_i == 32'h0)); // R10

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_i); // R10
endmodule

bind gpio_pad_irq_ctrl gpio_pad_irq_chk #(.LINES(gpio_pad_pkg::NUM_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .rsp_valid_i(rsp_valid_o),
  .rsp_err_i  (rsp_err_o),
  .rsp_rdata_i(rsp_rdata_o),
  .status_i   (status_w),
  .enable_i   (enable_w),
  .line_evt_i (line_evt),
  .clr_we_i   (stat_clr_we),
  .wdata_i    (req_wdata_i),
  .irq_i      (irq_o)
);

// File: tb/tb_gpio_pad_irq_ctrl.sv
module tb_gpio_pad_irq_ctrl;
  localparam int unsigned NP = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err, irq;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_pad_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .irq_o(irq)
  );

  function automatic logic [15:0] c0(input int p);
    return 16'(32'h4400 + 1024 * (p / 15) + 8 * (p % 15));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [15:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata; err = rsp_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] rd; logic e;
    bus(1'b1, a, d, rd, e);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic e;
    bus(1'b0, a, 32'h0, rd, e);
    chk(req, rd, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 pad_out", 32'(pad_out), 0);
    rd_chk("R12 status", 16'h0300, 0);
    rd_chk("R12 enable", 16'h0380, 0);
    rd_chk("R12 cfg1", c0(0) + 16'd4, 0);
    rd_chk("R12 cfg0", c0(3), 0);
  endtask

  task automatic t_regs();
    wr(16'h0380, 32'hFFFF_ABCD);
    rd_chk("R1 enable readback", 16'h0380, 32'h0000_ABCD);
    wr(16'h0380, 32'h0);
    rd_chk("R1 enable zero", 16'h0380, 0);
  endtask

  task automatic t_cfg0();
    wr(c0(3), 32'h5000_0002);
    @(negedge clk);
    chk("R4 pad_out driven", 32'(pad_out[3]), 1);
    rd_chk("R4 cfg0 readback", c0(3), 32'h5000_0002);
    wr(c0(0), 32'h0000_0001);
    rd_chk("R5 rx bit write ignored", c0(0), 0);
    pad_in[0] = 1'b1;
    settle();
    rd_chk("R5 rx bit synchronised", c0(0), 32'h0000_0001);
  endtask

  task automatic t_rise();
    wr(c0(3) + 16'd4, 32'h2);
    wr(16'h0380, 32'h0020);
    pad_in[3] = 1'b1; settle();
    rd_chk("R6 rising sets line5", 16'h0300, 32'h20);
    chk("R3 irq set", 32'(irq), 1);
    pad_in[3] = 1'b0; settle();
    rd_chk("R6 falling ignored in rise mode", 16'h0300, 32'h20);
    wr(16'h0300, 32'h0);
    rd_chk("R2 write zero keeps", 16'h0300, 32'h20);
    wr(16'h0300, 32'h20);
    rd_chk("R2 write one clears", 16'h0300, 0);
    repeat (2) @(negedge clk);
    chk("R3 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_fall();
    wr(c0(0), 32'h2000_0000);
    wr(c0(0) + 16'd4, 32'h1);
    pad_in[0] = 1'b0; settle();
    rd_chk("R6 falling sets line2", 16'h0300, 32'h4);
    wr(16'h0300, 32'hFFFF);
    rd_chk("R2 clear all", 16'h0300, 0);
  endtask

  task automatic t_both();
    wr(c0(7), 32'h9000_0000);
    wr(c0(7) + 16'd4, 32'h3);
    pad_in[7] = 1'b1; settle();
    rd_chk("R6 both rise", 16'h0300, 32'h200);
    wr(16'h0300, 32'h200);
    pad_in[7] = 1'b0; settle();
    rd_chk("R6 both fall", 16'h0300, 32'h200);
    wr(16'h0300, 32'h200);
  endtask

  task automatic t_level_inv();
    wr(c0(15), 32'hC000_0000);
    wr(c0(15) + 16'd4, 32'h44);
    settle();
    rd_chk("R7 inverted low is active", 16'h0300, 32'h1000);
    rd_chk("R7 cfg1 readback", c0(15) + 16'd4, 32'h44);
    rd_chk("R5 rx bit not inverted", c0(15), 32'hC000_0000);
    wr(16'h0300, 32'h1000);
    rd_chk("R8 clear loses while active", 16'h0300, 32'h1000);
    pad_in[15] = 1'b1; settle();
    wr(16'h0300, 32'h1000);
    rd_chk("R8 clear holds when inactive", 16'h0300, 0);
    wr(c0(15) + 16'd4, 32'h0);
  endtask

  task automatic t_other_code();
    wr(c0(20), 32'h1000_0000);
    wr(c0(20) + 16'd4, 32'h5);
    pad_in[20] = 1'b1; settle();
    pad_in[20] = 1'b0; settle();
    rd_chk("R6 code 5 no event", 16'h0300, 0);
  endtask

  task automatic t_or_mask();
    wr(c0(3), 32'hE000_0002);
    wr(c0(7), 32'hE000_0000);
    wr(c0(7) + 16'd4, 32'h2);
    wr(16'h0380, 32'h4000);
    pad_in[7] = 1'b1; settle();
    rd_chk("R9 second pad on line14", 16'h0300, 32'h4000);
    wr(16'h0300, 32'h4000);
    pad_in[3] = 1'b1; settle();
    rd_chk("R9 first pad on line14", 16'h0300, 32'h4000);
    chk("R3 irq on line14", 32'(irq), 1);
    wr(16'h0380, 32'h0);
    repeat (2) @(negedge clk);
    chk("R3 enable zero blocks", 32'(irq), 0);
    wr(16'h0300, 32'hFFFF);
  endtask

  task automatic t_access();
    logic [31:0] rd; logic e;
    bus(1'b0, 16'h0302, 32'h0, rd, e);
    chk("R10 unaligned err", 32'(e), 1);
    chk("R10 unaligned data", rd, 0);
    bus(1'b1, 16'h0381, 32'hFFFF, rd, e);
    chk("R10 unaligned write err", 32'(e), 1);
    rd_chk("R10 unaligned write ignored", 16'h0380, 0);
    bus(1'b0, 16'h4C00, 32'h0, rd, e);
    chk("R10 beyond map err", 32'(e), 1);
    bus(1'b0, 16'h4BFC, 32'h0, rd, e);
    chk("R11 in-range hole no err", 32'(e), 0);
  endtask

  task automatic t_nopad();
    logic [31:0] rd; logic e;
    bus(1'b1, c0(8), 32'hF000_0002, rd, e);
    chk("R11 absent pad write no err", 32'(e), 0);
    @(negedge clk);
    chk("R11 absent pad output", 32'(pad_out[8]), 0);
    rd_chk("R11 absent pad read", c0(8), 0);
    wr(16'h4478, 32'h2);
    rd_chk("R11 slot 15 read", 16'h4478, 0);
    wr(c0(21), 32'h2);
    @(negedge clk);
    chk("R11 absent group1 pad output", 32'(pad_out[21]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_cfg0();
    t_rise();
    t_fall();
    t_both();
    t_level_inv();
    t_other_code();
    t_or_mask();
    t_access();
    t_nopad();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule